// File: doc/BRIEF.md
# ADC Sample Trigger Scheduler

This block sequences up to sixteen sample slots onto one shared analog-to-digital converter. Every slot holds a small configuration: which event starts it, which analog channel it converts, how fast its start-delay counter runs, and how many delay ticks to wait. A slot is started either by a rising edge on its chosen hardware event or by a software start mask. It then counts out its delay and becomes ready. From that point until its conversion finishes, its pending flag is 1.

An arbiter hands the converter to one ready slot at a time. It issues a one-cycle start together with the slot's channel and index, and it holds a busy status until the converter returns a done pulse. That pulse frees the slot. Each slot also has a sticky overrun flag, set when a new start event arrives while the slot is still pending. A summary output shows whether any overrun flag is set.

Top module: `adc_trig_sched`

## Requirements
- R1: A configuration write (`cfgWe`) stores the source select, channel, divider code and delay count into the slot named by `cfgSlot`. The channel stored there is the value presented on `convChan` when that slot is granted.
- R2: Hardware event inputs are edge detected. Source code 1 selects `extStartPin`. Codes 2 and 3 select `eocPulse[0]` and `eocPulse[1]`. Codes 4 to 7 select `timerOvf[0..3]`. Codes 8 to 15 select `pwmTrig[0..7]`. Code 0 selects no hardware input. A level held high for several cycles counts as a single event.
- R3: A cycle with `swStartWe` high starts every slot n whose `swStartMask[n]` is 1, whatever its source select.
- R4: Divider code 0, 1, 2 or 3 gives one delay tick every 1, 2, 4 or 16 clocks, respectively. A slot becomes ready after its delay count of ticks, or at once when the count is 0. With code 0, delay D and an idle converter, `convStart` goes high D+1 clocks after the edge that captures the event.
- R5: `pendFlags[n]` is 1 from the edge that captures slot n's start until the edge that captures `convDone` for slot n's conversion. It then returns to 0.
- R6: When several slots are ready, the lowest-numbered one is granted first. `convStart` is a one-cycle pulse issued only while the converter is idle, with `convSlot` and `convChan` valid alongside it.
- R7: `convBusy` is 1 from the grant until the edge that captures `convDone`, and 0 otherwise.
- R8: A start event (hardware or software) that reaches a slot whose pending flag is 1 sets `ovfFlags` for that slot. `ovfAny` is 1 while any overrun flag is 1.
- R9: Overrun flags are sticky. They clear only when a cycle has `ovfClrWe` high and the matching `ovfClrMask` bit is 1; mask bits that are 0 leave their flags unchanged.
- R10: After reset, all slots are idle with configuration zero, and `convStart`, `convBusy`, `pendFlags`, `ovfFlags` and `ovfAny` are all 0.
- R11: A `convDone` pulse while the converter is idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Slot configuration write strobe |
| cfgSlot | input | 4 | Slot index for the configuration write |
| cfgTrigSel | input | 4 | Start source code |
| cfgChan | input | 4 | Analog channel number |
| cfgDiv | input | 2 | Delay tick divider code |
| cfgDelay | input | 8 | Delay count in ticks |
| swStartWe | input | 1 | Software start strobe |
| swStartMask | input | 16 | One bit per slot to start |
| extStartPin | input | 1 | External start event |
| eocPulse | input | 2 | End-of-conversion event lines |
| timerOvf | input | 4 | Timer overflow events |
| pwmTrig | input | 8 | PWM trigger events |
| convStart | output | 1 | One-cycle conversion start |
| convChan | output | 4 | Channel of the granted slot |
| convSlot | output | 4 | Index of the granted slot |
| convDone | input | 1 | Conversion finished pulse |
| convBusy | output | 1 | Converter working |
| pendFlags | output | 16 | Per-slot pending flags |
| ovfClrWe | input | 1 | Overrun clear strobe |
| ovfClrMask | input | 16 | Write-one-to-clear mask for overrun flags |
| ovfFlags | output | 16 | Per-slot sticky start overrun |
| ovfAny | output | 1 | Any overrun flag set |

## Verification
The assertions assume that `convDone` arrives only after a `convStart` and no earlier than the following cycle, so that the one-cycle start pulse and the busy hold both follow from the handshake. They also assume that a slot's configuration is not rewritten while that slot is pending. The stimulus pulses `convDone` only after it has seen `convStart`, except in the one scenario that deliberately pulses it while idle. Configuration writes are made only while every affected slot is idle.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;
  localparam int SLOTS   = 16;
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int EOC_N   = 2;
  localparam int TMR_N   = 4;
  localparam int PWM_N   = 8;
  localparam int SRC_NUM = 2 + EOC_N + TMR_N + PWM_N;
  localparam int SEL_W   = $clog2(SRC_NUM);
  localparam int CHAN_W  = 4;
  localparam int DIV_W   = 2;
  localparam int DLY_W   = 8;
  localparam int PRE_W   = 4;

  typedef struct packed {
    logic [SEL_W-1:0]  trigSel;
    logic [CHAN_W-1:0] chan;
    logic [DIV_W-1:0]  div;
    logic [DLY_W-1:0]  delay;
  } slotCfg_t;

  typedef enum logic [1:0] {
    SLOT_IDLE,
    SLOT_WAIT,
    SLOT_READY,
    SLOT_CONV
  } slotState_e;

  typedef struct packed {
    logic [SLOTS-1:0]  loadDly;
    logic [SLOTS-1:0]  stepDly;
    logic              grant;
    logic [SLOT_W-1:0] grantIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/adc_sched_dp.sv
module adc_sched_dp
  import adc_sched_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [SLOT_W-1:0]   cfgSlot,
  input  slotCfg_t            cfgWord,
  input  logic                swStartWe,
  input  logic [SLOTS-1:0]    swStartMask,
  input  logic [SRC_NUM-1:0]  hwSrc,
  input  ctlStrobe_t          strobe,
  output logic [SLOTS-1:0]    fireVec,
  output logic [SLOTS-1:0]    zeroDly,
  output logic [SLOTS-1:0]    lastStep,
  output logic [SLOTS-1:0]    tickVec,
  output logic [CHAN_W-1:0]   convChan
);
  slotCfg_t           cfgMem [SLOTS];
  logic [DLY_W-1:0]   dlyCnt [SLOTS];
  logic [SRC_NUM-1:0] srcPrev;
  logic [SRC_NUM-1:0] srcRise;
  logic [PRE_W-1:0]   preCnt;
  logic [CHAN_W-1:0]  chanQ;

  function automatic logic tickFor(input logic [DIV_W-1:0] code, input logic [PRE_W-1:0] pre);
    case (code)
      2'd0:    tickFor = 1'b1;
      2'd1:    tickFor = pre[0];
      2'd2:    tickFor = &pre[1:0];
      default: tickFor = &pre[3:0];
    endcase
  endfunction

  assign srcRise = hwSrc & ~srcPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPrev <= '0;
      preCnt  <= '0;
      chanQ   <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        cfgMem[i] <= '0;
        dlyCnt[i] <= '0;
      end
    end else begin
      srcPrev <= hwSrc;
      preCnt  <= preCnt + 1'b1;
      if (cfgWe) cfgMem[cfgSlot] <= cfgWord;
      if (strobe.grant) chanQ <= cfgMem[strobe.grantIdx].chan;
      for (int i = 0; i < SLOTS; i++) begin
        if (strobe.loadDly[i])      dlyCnt[i] <= cfgMem[i].delay;
        else if (strobe.stepDly[i]) dlyCnt[i] <= dlyCnt[i] - 1'b1;
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign fireVec[g]  = srcRise[cfgMem[g].trigSel] | (swStartWe & swStartMask[g]);
    assign zeroDly[g]  = (cfgMem[g].delay == '0);
    assign lastStep[g] = (dlyCnt[g] <= DLY_W'(1));
    assign tickVec[g]  = tickFor(cfgMem[g].div, preCnt);
  end

  assign convChan = chanQ;
endmodule

// File: rtl/adc_sched_ctl.sv
module adc_sched_ctl
  import adc_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SLOTS-1:0]  fireVec,
  input  logic [SLOTS-1:0]  zeroDly,
  input  logic [SLOTS-1:0]  lastStep,
  input  logic [SLOTS-1:0]  tickVec,
  input  logic              convDone,
  input  logic              ovfClrWe,
  input  logic [SLOTS-1:0]  ovfClrMask,
  output ctlStrobe_t        strobe,
  output logic              convStart,
  output logic [SLOT_W-1:0] convSlot,
  output logic              convBusy,
  output logic [SLOTS-1:0]  pendFlags,
  output logic [SLOTS-1:0]  ovfFlags,
  output logic              ovfAny
);
  slotState_e        st [SLOTS];
  logic [SLOTS-1:0]  readyVec, loadVec, stepVec, ovfQ;
  logic [SLOT_W-1:0] grantIdx, curSlot;
  logic              anyReady, grantGo, busyQ, startQ, doneHit;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      readyVec[i]  = (st[i] == SLOT_READY);
      pendFlags[i] = (st[i] != SLOT_IDLE);
      loadVec[i]   = (st[i] == SLOT_IDLE) && fireVec[i] && !zeroDly[i];
      stepVec[i]   = (st[i] == SLOT_WAIT) && tickVec[i] && !lastStep[i];
    end
  end

  // lowest index wins
  always_comb begin
    grantIdx = '0;
    anyReady = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (readyVec[i]) begin
        grantIdx = SLOT_W'(i);
        anyReady = 1'b1;
      end
    end
  end

  assign grantGo = !busyQ && anyReady;
  assign doneHit = busyQ && convDone;

  always_comb begin
    strobe.loadDly  = loadVec;
    strobe.stepDly  = stepVec;
    strobe.grant    = grantGo;
    strobe.grantIdx = grantIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      startQ  <= 1'b0;
      curSlot <= '0;
      ovfQ    <= '0;
      for (int i = 0; i < SLOTS; i++) st[i] <= SLOT_IDLE;
    end else begin
      startQ <= grantGo;
      if (grantGo) begin
        busyQ   <= 1'b1;
        curSlot <= grantIdx;
      end else if (doneHit) begin
        busyQ <= 1'b0;
      end
      for (int i = 0; i < SLOTS; i++) begin
        ovfQ[i] <= (ovfQ[i] & ~(ovfClrWe & ovfClrMask[i])) |
                   (fireVec[i] & (st[i] != SLOT_IDLE));
        case (st[i])
          SLOT_IDLE:  if (fireVec[i]) st[i] <= zeroDly[i] ? SLOT_READY : SLOT_WAIT;
          SLOT_WAIT:  if (tickVec[i] && lastStep[i]) st[i] <= SLOT_READY;
          SLOT_READY: if (grantGo && grantIdx == SLOT_W'(i)) st[i] <= SLOT_CONV;
          SLOT_CONV:  if (doneHit && curSlot == SLOT_W'(i)) st[i] <= SLOT_IDLE;
          default:    st[i] <= SLOT_IDLE;
        endcase
      end
    end
  end

  assign convStart = startQ;
  assign convSlot  = curSlot;
  assign convBusy  = busyQ;
  assign ovfFlags  = ovfQ;
  assign ovfAny    = |ovfQ;
endmodule

// File: rtl/adc_trig_sched.sv
module adc_trig_sched
  import adc_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [SEL_W-1:0]  cfgTrigSel,
  input  logic [CHAN_W-1:0] cfgChan,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic [DLY_W-1:0]  cfgDelay,
  input  logic              swStartWe,
  input  logic [SLOTS-1:0]  swStartMask,
  input  logic              extStartPin,
  input  logic [EOC_N-1:0]  eocPulse,
  input  logic [TMR_N-1:0]  timerOvf,
  input  logic [PWM_N-1:0]  pwmTrig,
  output logic              convStart,
  output logic [CHAN_W-1:0] convChan,
  output logic [SLOT_W-1:0] convSlot,
  input  logic              convDone,
  output logic              convBusy,
  output logic [SLOTS-1:0]  pendFlags,
  input  logic              ovfClrWe,
  input  logic [SLOTS-1:0]  ovfClrMask,
  output logic [SLOTS-1:0]  ovfFlags,
  output logic              ovfAny
);
  slotCfg_t           cfgWord;
  ctlStrobe_t         strobe;
  logic [SRC_NUM-1:0] hwSrc;
  logic [SLOTS-1:0]   fireVec, zeroDly, lastStep, tickVec;

  assign cfgWord = '{trigSel: cfgTrigSel, chan: cfgChan, div: cfgDiv, delay: cfgDelay};
  // code 0 carries no hardware event
  assign hwSrc   = {pwmTrig, timerOvf, eocPulse, extStartPin, 1'b0};

  adc_sched_dp u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSlot(cfgSlot), .cfgWord(cfgWord),
    .swStartWe(swStartWe), .swStartMask(swStartMask), .hwSrc(hwSrc), .strobe(strobe),
    .fireVec(fireVec), .zeroDly(zeroDly), .lastStep(lastStep), .tickVec(tickVec),
    .convChan(convChan)
  );

  adc_sched_ctl u_ctl (
    .clk(clk), .rstN(rstN), .fireVec(fireVec), .zeroDly(zeroDly), .lastStep(lastStep),
    .tickVec(tickVec), .convDone(convDone), .ovfClrWe(ovfClrWe), .ovfClrMask(ovfClrMask),
    .strobe(strobe), .convStart(convStart), .convSlot(convSlot), .convBusy(convBusy),
    .pendFlags(pendFlags), .ovfFlags(ovfFlags), .ovfAny(ovfAny)
  );
endmodule

// File: rtl/adc_trig_sched_chk.sv
module adc_trig_sched_chk
  import adc_sched_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              convStart,
  input logic [SLOT_W-1:0] convSlot,
  input logic              convBusy,
  input logic              convDone,
  input logic [SLOTS-1:0]  pendFlags,
  input logic [SLOTS-1:0]  ovfFlags,
  input logic              ovfClrWe
);
  // R6: a granted slot is pending and the converter is marked busy
  a_r6_start_pending: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> (pendFlags[convSlot] && convBusy));

  // R6: start is a single-cycle pulse
  a_r6_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R7: busy holds until done
  a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (convBusy && !convDone) |=> convBusy);

  // R5: done releases the slot being converted
  a_r5_pend_release: assert property (@(posedge clk) disable iff (!rstN)
    (convBusy && convDone) |=> !pendFlags[$past(convSlot)]);

  // R9: without a clear write no overrun flag falls
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !ovfClrWe |=> (($past(ovfFlags) & ~ovfFlags) == '0));

  // R8: a new overrun only appears on a slot that was pending
  a_r8_ovf_needs_pend: assert property (@(posedge clk) disable iff (!rstN)
    ((ovfFlags & ~$past(ovfFlags) & ~$past(pendFlags)) == '0));
endmodule

bind adc_trig_sched adc_trig_sched_chk u_chk (.*);

// File: tb/adc_trig_sched_tb.sv
`timescale 1ns/1ps
module adc_trig_sched_tb;
  import adc_sched_pkg::*;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 0; logic [SLOT_W-1:0] cfgSlot = '0; logic [SEL_W-1:0] cfgTrigSel = '0;
  logic [CHAN_W-1:0] cfgChan = '0; logic [DIV_W-1:0] cfgDiv = '0; logic [DLY_W-1:0] cfgDelay = '0;
  logic swStartWe = 0; logic [SLOTS-1:0] swStartMask = '0;
  logic extStartPin = 0; logic [EOC_N-1:0] eocPulse = '0; logic [TMR_N-1:0] timerOvf = '0;
  logic [PWM_N-1:0] pwmTrig = '0;
  logic convStart, convBusy, ovfAny; logic [CHAN_W-1:0] convChan; logic [SLOT_W-1:0] convSlot;
  logic convDone = 0, ovfClrWe = 0; logic [SLOTS-1:0] ovfClrMask = '0;
  logic [SLOTS-1:0] pendFlags, ovfFlags;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_trig_sched u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfgWr(input int slot, input int sel, input int ch, input int dv, input int dly);
    cfgWe = 1; cfgSlot = SLOT_W'(slot); cfgTrigSel = SEL_W'(sel);
    cfgChan = CHAN_W'(ch); cfgDiv = DIV_W'(dv); cfgDelay = DLY_W'(dly);
    @(negedge clk); cfgWe = 0;
  endtask

  task automatic setSrc(input int code, input logic v);
    if (code == 1) extStartPin = v;
    else if (code < 4) eocPulse[code-2] = v;
    else if (code < 8) timerOvf[code-4] = v;
    else pwmTrig[code-8] = v;
  endtask

  task automatic pulseSrc(input int code);
    setSrc(code, 1'b1); @(negedge clk); setSrc(code, 1'b0);
  endtask

  task automatic swStart(input logic [SLOTS-1:0] m);
    swStartWe = 1; swStartMask = m; @(negedge clk); swStartWe = 0; swStartMask = '0;
  endtask

  // counts negedges from the one that raised the event
  task automatic waitStart(output int lat);
    lat = 1;
    while (!convStart && lat < 200) begin @(negedge clk); lat++; end
  endtask

  task automatic finishConv();
    convDone = 1; @(negedge clk); convDone = 0;
  endtask

  task automatic test_reset();
    check(convStart == 0, "R10 convStart", convStart, 0);
    check(convBusy == 0, "R10 convBusy", convBusy, 0);
    check(pendFlags == 0, "R10 pendFlags", pendFlags, 0);
    check(ovfFlags == 0 && ovfAny == 0, "R10 overrun", ovfFlags, 0);
  endtask

  task automatic test_sel0();
    extStartPin = 1; eocPulse = '1; timerOvf = '1; pwmTrig = '1;
    @(negedge clk);
    extStartPin = 0; eocPulse = '0; timerOvf = '0; pwmTrig = '0;
    check(pendFlags == 0, "R2 code0 ignores hardware", pendFlags, 0);
    @(negedge clk);
    check(convStart == 0 && convBusy == 0, "R2 code0 no start", convStart, 0);
  endtask

  task automatic test_sw_single();
    int lat;
    cfgWr(3, 0, 5, 0, 0);
    swStart(16'h0008);
    check(pendFlags == 16'h0008, "R3 sw start pending", pendFlags, 8);
    waitStart(lat);
    check(lat == 2, "R4 zero delay latency", lat, 2);
    check(convSlot == 3, "R6 slot", convSlot, 3);
    check(convChan == 5, "R1 channel", convChan, 5);
    check(convBusy == 1, "R7 busy at start", convBusy, 1);
    @(negedge clk);
    check(convBusy == 1 && pendFlags[3], "R7 busy held", convBusy, 1);
    finishConv();
    check(convBusy == 0, "R7 busy released", convBusy, 0);
    check(pendFlags == 0, "R5 pending cleared", pendFlags, 0);
  endtask

  task automatic test_delay();
    int lat;
    cfgWr(6, 6, 9, 0, 5);
    pulseSrc(6);
    check(pendFlags == 16'h0040, "R5 pending during delay", pendFlags, 16'h40);
    waitStart(lat);
    check(lat == 7, "R4 delay 5 latency", lat, 7);
    check(convChan == 9, "R1 channel delayed", convChan, 9);
    finishConv();
  endtask

  task automatic test_sources();
    int lat;
    for (int c = 1; c < SRC_NUM; c++) begin
      cfgWr(c, c, 15 - c, 0, 0);
      pulseSrc(c);
      check(pendFlags == (1 << c), "R2 source mapping", pendFlags, 1 << c);
      waitStart(lat);
      check(convSlot == c, "R2 source slot", convSlot, c);
      check(convChan == 15 - c, "R1 source channel", convChan, 15 - c);
      finishConv();
    end
  endtask

  task automatic test_level();
    extStartPin = 1; @(negedge clk);
    check(pendFlags == 16'h0002, "R2 level first edge", pendFlags, 2);
    @(negedge clk);
    check(convStart && convSlot == 1, "R2 level start", convSlot, 1);
    finishConv();
    @(negedge clk); extStartPin = 0; @(negedge clk);
    check(pendFlags == 0, "R2 held level single event", pendFlags, 0);
    check(ovfFlags == 0, "R2 held level no overrun", ovfFlags, 0);
  endtask

  task automatic test_priority();
    int lat;
    int order [3] = '{2, 7, 12};
    cfgWr(2, 0, 2, 0, 0); cfgWr(7, 0, 7, 0, 0); cfgWr(12, 0, 12, 0, 0);
    swStart(16'h1084);
    check(pendFlags == 16'h1084, "R3 mask pending", pendFlags, 16'h1084);
    for (int k = 0; k < 3; k++) begin
      waitStart(lat);
      check(convSlot == order[k], "R6 lowest first", convSlot, order[k]);
      check(convChan == order[k], "R6 channel with grant", convChan, order[k]);
      finishConv();
    end
    check(pendFlags == 0, "R5 all released", pendFlags, 0);
  endtask

  task automatic test_div();
    int lat, per, lo, hi;
    for (int d = 0; d < 4; d++) begin
      per = (d == 0) ? 1 : (d == 1) ? 2 : (d == 2) ? 4 : 16;
      cfgWr(5, 0, 3, d, 3);
      swStart(16'h0020);
      waitStart(lat);
      lo = 2 * per + 3; hi = 3 * per + 2;
      check(lat >= lo && lat <= hi, "R4 divider latency", lat, hi);
      finishConv();
    end
  endtask

  task automatic test_overrun();
    int lat;
    cfgWr(4, 4, 1, 0, 10);
    pulseSrc(4); @(negedge clk); @(negedge clk);
    check(ovfFlags == 0, "R8 no overrun yet", ovfFlags, 0);
    pulseSrc(4);
    check(ovfFlags == 16'h0010, "R8 overrun flag", ovfFlags, 16'h10);
    check(ovfAny == 1, "R8 summary", ovfAny, 1);
    waitStart(lat); finishConv();
    check(ovfFlags == 16'h0010, "R9 sticky", ovfFlags, 16'h10);
    ovfClrWe = 1; ovfClrMask = 16'h0020; @(negedge clk); ovfClrWe = 0; ovfClrMask = '0;
    check(ovfFlags == 16'h0010, "R9 other mask bit", ovfFlags, 16'h10);
    ovfClrWe = 1; ovfClrMask = 16'h0010; @(negedge clk); ovfClrWe = 0; ovfClrMask = '0;
    check(ovfFlags == 0, "R9 clear", ovfFlags, 0);
    check(ovfAny == 0, "R8 summary clear", ovfAny, 0);
  endtask

  task automatic test_spurious();
    finishConv();
    check(convBusy == 0 && pendFlags == 0, "R11 idle done ignored", convBusy, 0);
    @(negedge clk);
    check(convStart == 0, "R11 no start", convStart, 0);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      report();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    test_reset();
    test_sel0();
    test_sw_single();
    test_delay();
    test_sources();
    test_level();
    test_priority();
    test_div();
    test_overrun();
    test_spurious();
    done = 1;
    report();
  end
endmodule